// File: doc/BRIEF.md
# Pixel Color Component Extractor

This block turns one packed pixel word, read from a frame buffer, into three 8-bit color components: red, green and blue. Software configures the block through a small write-only register file. One register gives the number of bytes each pixel occupies. Each color has its own select register, which gives three things:

- the lowest bit position of the component in the word,
- how many bits the component spans,
- a fallback value.

On every valid pixel the block does the following:

- It clears the bytes of the input word that lie beyond the configured pixel size.
- It cuts out each color field.
- It widens each field to 8 bits by repeating its upper bits.
- It registers the three results together with a delayed copy of the visible flag.

Each color shows its fallback value instead of the extracted field in three cases: its length is zero, the pixel lies in blanking, or the pixel source reports an underrun. The underrun case lets a display show a chosen color when data is missing.

Top module: `pcx_color_unpack`

## Requirements
- R1: After reset, out_valid, out_visible and all three components are 0. Every register field is also 0, which means 1 byte per pixel and zero length with fallback 0 for each color.
- R2: Register writes use cfg_addr. Address 0 is the format register, whose bits [4:3] hold bytes-per-pixel minus one. Addresses 1, 2 and 3 are the red, green and blue select registers. In a select register, bits [23:16] hold the fallback value, bits [11:8] the bit count and bits [4:0] the lowest bit index. A write at a clock edge applies to pixels accepted from the next edge onward. A pixel accepted at the same edge as a write still uses the old settings.
- R3: Bytes of pix_word above the configured pixel size read as zero before extraction. For example, with a 2-byte format only bits [15:0] count.
- R4: A component takes its bits from the lowest bit index upward. Positions past bit 31 read as zero.
- R5: A bit count above 8 acts as 8.
- R6: A field of n bits, with 1 ≤ n < 8, is widened as follows: output bit (7−k) equals field bit (n−1−(k mod n)) for k = 0..7. A field of exactly 8 bits passes through unchanged.
- R7: A color whose bit count is 0 outputs its fallback value.
- R8: When pix_visible is 0, all three colors output their fallback values.
- R9: When pix_underrun is 1, all three colors output their fallback values.
- R10: The results of a pixel accepted with pix_valid at one edge appear at that edge, together with out_visible. out_valid is high exactly in the cycle after an accepted pixel. While pix_valid is low, the components and out_visible hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 format, 1 red, 2 green, 3 blue |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel word present this cycle |
| pix_word | input | 32 | Packed pixel word |
| pix_visible | input | 1 | Pixel lies inside the visible area |
| pix_underrun | input | 1 | Pixel source had no data |
| out_valid | output | 1 | Components updated this cycle |
| out_visible | output | 1 | Visible flag aligned to the components |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |

## Verification
The pixel path has exactly one register stage. Components, out_visible and out_valid are therefore due at the first clock edge after the pixel is accepted. The bench drives inputs on the falling edge and reads the outputs on the next falling edge, which is just after that rising edge. A register write is issued alone in one cycle, so it is in force for the next pixel. One directed case instead presents a write and a pixel in the same cycle and expects the pixel to use the old settings. Hold behaviour is checked on the cycle after pix_valid drops.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
    parameter int PIX_W   = 32;
    parameter int COMP_W  = 8;
    parameter int LEN_W   = 4;
    parameter int IDX_W   = 5;
    parameter int NUM_CH  = 3;
    parameter int BPP_LSB = 3;
    parameter int BPP_W   = 2;
    parameter int DFLT_LSB = 16;
    parameter int LEN_LSB  = 8;
    parameter int IDX_LSB  = 0;

    localparam int ADDR_W = $clog2(NUM_CH + 1);
    localparam int BYTES  = PIX_W / 8;

    typedef struct packed {
        logic [COMP_W-1:0] dflt;
        logic [LEN_W-1:0]  len;
        logic [IDX_W-1:0]  low;
    } chan_cfg_t;

    typedef struct packed {
        logic [BPP_W-1:0]                bpp_m1;
        logic [NUM_CH-1:0][$bits(chan_cfg_t)-1:0] ch;
    } cfg_regs_t;

    typedef struct packed {
        logic                            vld;
        logic                            vis;
        logic [NUM_CH-1:0][COMP_W-1:0]   comp;
    } out_stage_t;
endpackage

// File: rtl/pcx_cfg_regs.sv
module pcx_cfg_regs
    import pcx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PIX_W-1:0]  wdata,
    output logic [BPP_W-1:0]  bpp_m1,
    output chan_cfg_t         ch_cfg [NUM_CH]
);
    cfg_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            if (addr == '0) begin
                regs_d.bpp_m1 = wdata[BPP_LSB +: BPP_W];
            end else begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (int'(addr) == c + 1) begin
                        regs_d.ch[c] = {wdata[DFLT_LSB +: COMP_W],
                                        wdata[LEN_LSB +: LEN_W],
                                        wdata[IDX_LSB +: IDX_W]};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bpp_m1 = regs_q.bpp_m1;
    for (genvar c = 0; c < NUM_CH; c++) begin : g_out
        assign ch_cfg[c] = chan_cfg_t'(regs_q.ch[c]);
    end

    // R2: a write to the format register lands in the stored field one edge later
    a_r2_fmt_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we && addr == '0) |-> bpp_m1 == $past(wdata[BPP_LSB +: BPP_W]));
endmodule

// File: rtl/pcx_byte_mask.sv
module pcx_byte_mask
    import pcx_pkg::*;
(
    input  logic [PIX_W-1:0] word_in,
    input  logic [BPP_W-1:0] bpp_m1,
    output logic [PIX_W-1:0] word_out
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign word_out[b*8 +: 8] = (b <= int'(bpp_m1)) ? word_in[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/pcx_chan_extract.sv
module pcx_chan_extract
    import pcx_pkg::*;
(
    input  logic [PIX_W-1:0]  word,
    input  chan_cfg_t         cfg,
    input  logic              force_dflt,
    output logic [COMP_W-1:0] comp
);
    logic [PIX_W-1:0]  shifted;
    logic [COMP_W-1:0] field;
    logic [COMP_W-1:0] widened;
    int unsigned       n_eff;

    always_comb begin
        shifted = word >> cfg.low;
        n_eff   = (int'(cfg.len) > COMP_W) ? COMP_W : int'(cfg.len);
        field   = '0;
        for (int b = 0; b < COMP_W; b++) begin
            if (b < n_eff) field[b] = shifted[b];
        end
        widened = '0;
        if (n_eff != 0) begin
            for (int k = 0; k < COMP_W; k++) begin
                widened[COMP_W-1-k] = field[n_eff - 1 - (k % n_eff)];
            end
        end
        comp = (force_dflt || n_eff == 0) ? cfg.dflt : widened;
    end
endmodule

// File: rtl/pcx_color_unpack.sv
module pcx_color_unpack
    import pcx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        pix_valid,
    input  logic [31:0] pix_word,
    input  logic        pix_visible,
    input  logic        pix_underrun,
    output logic        out_valid,
    output logic        out_visible,
    output logic [7:0]  out_red,
    output logic [7:0]  out_green,
    output logic [7:0]  out_blue
);
    logic [BPP_W-1:0]  bpp_m1;
    chan_cfg_t         ch_cfg [NUM_CH];
    logic [PIX_W-1:0]  masked;
    logic [COMP_W-1:0] comp_c [NUM_CH];
    logic              force_dflt;
    out_stage_t        st_d, st_q;

    pcx_cfg_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .bpp_m1 (bpp_m1),
        .ch_cfg (ch_cfg)
    );

    pcx_byte_mask u_mask (
        .word_in  (pix_word),
        .bpp_m1   (bpp_m1),
        .word_out (masked)
    );

    assign force_dflt = !pix_visible || pix_underrun;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pcx_chan_extract u_ext (
            .word       (masked),
            .cfg        (ch_cfg[c]),
            .force_dflt (force_dflt),
            .comp       (comp_c[c])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = pix_valid;
        if (pix_valid) begin
            st_d.vis = pix_visible;
            for (int c = 0; c < NUM_CH; c++) st_d.comp[c] = comp_c[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_visible = st_q.vis;
    assign out_red     = st_q.comp[0];
    assign out_green   = st_q.comp[1];
    assign out_blue    = st_q.comp[2];

    // R10: outputs follow the accepted pixel by one edge
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(pix_valid));
    // R10: idle cycles leave the components untouched
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pix_valid) |-> ($stable(out_red) && $stable(out_green) && $stable(out_blue)));
    // R8: a blanked pixel shows the red fallback held in the register file
    a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pix_valid && !pix_visible) |-> out_red == $past(ch_cfg[0].dflt));
    // R9: an underrun shows the green fallback
    a_r9_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pix_valid && pix_underrun) |-> out_green == $past(ch_cfg[1].dflt));
    // R7: a zero-length blue field shows its fallback
    a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pix_valid && ch_cfg[2].len == '0) |-> out_blue == $past(ch_cfg[2].dflt));
endmodule

// File: tb/pcx_color_unpack_tb.sv
module pcx_color_unpack_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [31:0] pix_word = '0;
    logic        pix_visible = 1'b0;
    logic        pix_underrun = 1'b0;
    logic        out_valid, out_visible;
    logic [7:0]  out_red, out_green, out_blue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0] m_bm1;
    logic [7:0] m_dflt [3];
    logic [3:0] m_len  [3];
    logic [4:0] m_low  [3];
    logic [7:0] last_c [3];
    logic       last_vis;

    always #5 clk = ~clk;

    pcx_color_unpack dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_valid(pix_valid), .pix_word(pix_word),
        .pix_visible(pix_visible), .pix_underrun(pix_underrun),
        .out_valid(out_valid), .out_visible(out_visible),
        .out_red(out_red), .out_green(out_green), .out_blue(out_blue)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [31:0] w, input int c, input logic vis, input logic und);
        logic [31:0] mw, sh;
        logic [7:0]  f, r;
        int n;
        for (int b = 0; b < 4; b++) mw[b*8 +: 8] = (b <= int'(m_bm1)) ? w[b*8 +: 8] : 8'h00;
        sh = mw >> m_low[c];
        n = (m_len[c] > 4'd8) ? 8 : int'(m_len[c]);
        if (!vis || und || n == 0) return m_dflt[c];
        f = sh[7:0] & 8'((9'd1 << n) - 9'd1);
        for (int k = 0; k < 8; k++) r[7-k] = f[n - 1 - (k % n)];
        return r;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 2'd0) m_bm1 = d[4:3];
        else begin
            m_dflt[a-1] = d[23:16]; m_len[a-1] = d[11:8]; m_low[a-1] = d[4:0];
        end
    endtask

    function automatic logic [31:0] sel(input logic [7:0] dflt, input logic [3:0] len, input logic [4:0] low);
        return {8'h00, dflt, 4'h0, len, 3'b000, low};
    endfunction

    task automatic pix(input string req, input logic [31:0] w, input logic vis, input logic und);
        logic [7:0] e [3];
        for (int c = 0; c < 3; c++) e[c] = model(w, c, vis, und);
        pix_valid = 1'b1; pix_word = w; pix_visible = vis; pix_underrun = und;
        @(negedge clk);
        pix_valid = 1'b0;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " visible"}, 32'(out_visible), 32'(vis));
        check({req, " red"}, 32'(out_red), 32'(e[0]));
        check({req, " green"}, 32'(out_green), 32'(e[1]));
        check({req, " blue"}, 32'(out_blue), 32'(e[2]));
        last_c[0] = out_red; last_c[1] = out_green; last_c[2] = out_blue; last_vis = out_visible;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        m_bm1 = '0;
        for (int c = 0; c < 3; c++) begin m_dflt[c] = '0; m_len[c] = '0; m_low[c] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", 32'(out_valid), 0);
        check("R1 comps", {8'h0, out_red, out_green, out_blue}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: zero length on all colors gives fallback 0
        pix("R1 cfg", 32'hffff_ffff, 1'b1, 1'b0);

        // R2/R3: 2-byte 565-style layout, upper bytes masked
        wr(2'd0, 32'h0000_0008);
        wr(2'd1, sel(8'h11, 4'd5, 5'd11));
        wr(2'd2, sel(8'h22, 4'd6, 5'd5));
        wr(2'd3, sel(8'h33, 4'd5, 5'd0));
        pix("R3 mask", 32'hffff_0000, 1'b1, 1'b0);
        check("R3 red masked", 32'(out_red), 0);
        pix("R2 layout", 32'h0000_f81f, 1'b1, 1'b0);
        // R6 replication: 3-bit 101 -> 10110110
        wr(2'd1, sel(8'h00, 4'd3, 5'd0));
        pix("R6 widen", 32'h0000_0005, 1'b1, 1'b0);
        check("R6 literal", 32'(out_red), 32'hb6);
        // R4: index 30, 8 bits, 4-byte format, top bits beyond 31 are zero
        wr(2'd0, 32'h0000_0018);
        wr(2'd1, sel(8'h00, 4'd8, 5'd30));
        pix("R4 edge", 32'hc000_0000, 1'b1, 1'b0);
        check("R4 literal", 32'(out_red), 32'h03);
        // R5: count 12 acts as 8
        wr(2'd2, sel(8'h00, 4'd12, 5'd8));
        pix("R5 clamp", 32'h00a5_5a00, 1'b1, 1'b0);
        check("R5 literal", 32'(out_green), 32'h5a);
        // R7 zero length fallback
        wr(2'd3, sel(8'h7e, 4'd0, 5'd0));
        pix("R7 zero", 32'h1234_5678, 1'b1, 1'b0);
        check("R7 literal", 32'(out_blue), 32'h7e);
        // R8 blanking, R9 underrun
        wr(2'd1, sel(8'hc3, 4'd8, 5'd0));
        pix("R8 blank", 32'h1234_5678, 1'b0, 1'b0);
        check("R8 literal", 32'(out_red), 32'hc3);
        pix("R9 underrun", 32'h1234_5678, 1'b1, 1'b1);
        check("R9 literal", 32'(out_red), 32'hc3);
        // R10 hold while idle
        pix_word = 32'hdead_beef; pix_visible = 1'b0;
        @(negedge clk);
        check("R10 valid low", 32'(out_valid), 0);
        check("R10 hold red", 32'(out_red), 32'(last_c[0]));
        check("R10 hold vis", 32'(out_visible), 32'(last_vis));
        // R2 same-cycle write uses old settings
        begin
            logic [7:0] e_old;
            e_old = model(32'h0000_00f0, 0, 1'b1, 1'b0);
            cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = sel(8'h00, 4'd4, 5'd4);
            pix_valid = 1'b1; pix_word = 32'h0000_00f0; pix_visible = 1'b1; pix_underrun = 1'b0;
            @(negedge clk);
            cfg_we = 1'b0; pix_valid = 1'b0;
            check("R2 same cycle", 32'(out_red), 32'(e_old));
            m_dflt[0] = 8'h00; m_len[0] = 4'd4; m_low[0] = 5'd4;
            pix("R2 after write", 32'h0000_00f0, 1'b1, 1'b0);
        end
        // random mix: R2..R10
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 3) == 0) wr(2'($urandom_range(0, 3)), $urandom);
            pix("R10 random", $urandom, ($urandom_range(0, 7) != 0), ($urandom_range(0, 9) == 0));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule